// File: doc/BRIEF.md
# Pipelined Quarter-Wave Sine/Cosine Oscillator

This block is a numerically controlled oscillator that turns a frequency tuning word into a stream of signed sine and cosine samples. A wide phase register adds the tuning word (plus an optional small dither term) once per enabled clock. The upper phase bits then address a lookup of one quarter of a sine period, and the full wave is rebuilt from that quarter by mirroring the address and negating the value.

The datapath is cut into four register stages so that no long path remains between flops: phase accumulation, lookup, sign preparation and quadrant selection. The sum of tuning word and dither is registered one step ahead of the accumulator, so two wide additions never chain in one cycle. A valid flag travels beside the data. A mixer or a sample stream downstream uses it to know which output cycles carry a new sample.

Top module: `quarter_wave_nco`

## Requirements
- R1: While `rstN` is low, `sine`, `cosine` and `outValid` are 0 and the phase register is cleared.
- R2: On every clock edge where `enable` is high, the phase advances by the registered increment, modulo 2^PHASE_W. With zero dither, after N enabled edges the phase equals N times the tuning word modulo 2^PHASE_W.
- R3: The increment is `tuningWord` plus `dither` zero-extended, taken into a register on every edge. A change on either input therefore first moves the phase on the enabled edge after the one that registers it.
- R4: On an edge where `enable` is low, the phase keeps its value.
- R5: `outValid` equals `enable` delayed by four clock edges. When `outValid` is high, the outputs show the sample for the phase produced by the edge four edges earlier.
- R6: While `outValid` is low, `sine` and `cosine` keep their previous values.
- R7: The quadrant is phase bits [PHASE_W-1:PHASE_W-2]. The table address is the next ADDR_W bits below them. Table entry k equals round(A·sin(π/2·(k+0.5)/2^ADDR_W)), with A = 2^(AMP_W-1)-1.
- R8: For sine, quadrants 1 and 3 use the bitwise-inverted address, quadrants 2 and 3 negate the table value, and quadrants 0 and 1 use it as is.
- R9: Cosine follows the R8 rules with the quadrant replaced by (quadrant+1) mod 4.
- R10: Outputs are two's complement and never take the most negative code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance phase and launch a sample |
| tuningWord | input | PHASE_W | Phase increment per enabled clock |
| dither | input | DITHER_W | Unsigned term added to the increment |
| sine | output | AMP_W | Signed sine sample |
| cosine | output | AMP_W | Signed cosine sample |
| outValid | output | 1 | Marks a new sample on the outputs |

## Verification
The bench builds the oscillator with PHASE_W=12, ADDR_W=4, AMP_W=12 and DITHER_W=4. With these values, a unit-step run visits all 4096 phases, wraps the accumulator and reaches every table entry in every quadrant for both outputs. A stride sweep then covers a wide range of tuning words, and a dither run covers all 16 dither codes. Mixed enable patterns test the four-clock latency, the holding of the phase and outputs, and a reset in mid-run.

// File: rtl/qnco_pkg.sv
package qnco_pkg;
  localparam int NCO_STAGES = 4;

  // Per-stage load strobes issued by the control to the datapath.
  typedef struct packed {
    logic [NCO_STAGES-1:0] stageLoad;
  } qnco_strobe_t;
endpackage

// File: rtl/qnco_ctrl.sv
module qnco_ctrl
  import qnco_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  output qnco_strobe_t strobes,
  output logic         outValid
);
  logic [NCO_STAGES-1:0] vldPipe;

  // R5: enable delayed through one flag per pipeline stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[NCO_STAGES-2:0], enable};
  end

  // Stage 1 loads on enable, each later stage when its predecessor holds new data
  always_comb begin
    strobes.stageLoad = {vldPipe[NCO_STAGES-2:0], enable};
  end

  assign outValid = vldPipe[NCO_STAGES-1];
endmodule

// File: rtl/qnco_datapath.sv
module qnco_datapath
  import qnco_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 8,
  parameter int AMP_W    = 16,
  parameter int DITHER_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PHASE_W-1:0]       tuningWord,
  input  logic [DITHER_W-1:0]      dither,
  input  qnco_strobe_t             strobes,
  output logic signed [AMP_W-1:0]  sine,
  output logic signed [AMP_W-1:0]  cosine
);
  localparam int  QDEPTH   = 1 << ADDR_W;
  localparam int  MAG_W    = AMP_W - 1;
  localparam int  QUAD_LSB = PHASE_W - 2;
  localparam int  ADDR_LSB = QUAD_LSB - ADDR_W;
  localparam real HALF_PI  = 1.5707963267948966;
  localparam real AMP_MAX  = real'((1 << (AMP_W - 1)) - 1);

  // R7: quarter-wave table computed at elaboration
  logic [MAG_W-1:0] quarterRom [QDEPTH];
  for (genvar k = 0; k < QDEPTH; k++) begin : g_rom
    localparam real ANGLE = HALF_PI * (real'(k) + 0.5) / real'(QDEPTH);
    localparam int  VAL   = $rtoi(AMP_MAX * $sin(ANGLE) + 0.5);
    assign quarterRom[k] = MAG_W'(VAL);
  end

  // R3: registered dithered increment
  logic [PHASE_W-1:0] incReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) incReg <= '0;
    else       incReg <= tuningWord + {{(PHASE_W-DITHER_W){1'b0}}, dither};
  end

  // Stage 1: accumulate in place (R2, R4)
  logic [PHASE_W-1:0] phaseAcc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        phaseAcc <= '0;
    else if (strobes.stageLoad[0])    phaseAcc <= phaseAcc + incReg;
  end

  // Stage 2: table read of direct and mirrored address
  logic [1:0]        quad2;
  logic [ADDR_W-1:0] addr1;
  logic [MAG_W-1:0]  magDirect, magMirror;
  assign addr1 = phaseAcc[ADDR_LSB +: ADDR_W];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quad2     <= '0;
      magDirect <= '0;
      magMirror <= '0;
    end else if (strobes.stageLoad[1]) begin
      quad2     <= phaseAcc[QUAD_LSB +: 2];
      magDirect <= quarterRom[addr1];
      magMirror <= quarterRom[~addr1];
    end
  end

  // Stage 3: positive and negated copies
  logic [1:0]              quad3;
  logic signed [AMP_W-1:0] extDirect, extMirror;
  logic signed [AMP_W-1:0] posDirect, negDirect, posMirror, negMirror;
  always_comb begin
    extDirect = {1'b0, magDirect};
    extMirror = {1'b0, magMirror};
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quad3     <= '0;
      posDirect <= '0;
      negDirect <= '0;
      posMirror <= '0;
      negMirror <= '0;
    end else if (strobes.stageLoad[2]) begin
      quad3     <= quad2;
      posDirect <= extDirect;
      negDirect <= -extDirect;
      posMirror <= extMirror;
      negMirror <= -extMirror;
    end
  end

  // Stage 4: quadrant multiplexer (R8 sine, R9 cosine on quadrant+1)
  logic signed [AMP_W-1:0] sinSel, cosSel;
  always_comb begin
    unique case (quad3)
      2'd0:    begin sinSel = posDirect; cosSel = posMirror; end
      2'd1:    begin sinSel = posMirror; cosSel = negDirect; end
      2'd2:    begin sinSel = negDirect; cosSel = negMirror; end
      default: begin sinSel = negMirror; cosSel = posDirect; end
    endcase
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sine   <= '0;
      cosine <= '0;
    end else if (strobes.stageLoad[3]) begin
      sine   <= sinSel;
      cosine <= cosSel;
    end
  end
endmodule

// File: rtl/quarter_wave_nco.sv
module quarter_wave_nco
  import qnco_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 8,
  parameter int AMP_W    = 16,
  parameter int DITHER_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [PHASE_W-1:0]      tuningWord,
  input  logic [DITHER_W-1:0]     dither,
  output logic signed [AMP_W-1:0] sine,
  output logic signed [AMP_W-1:0] cosine,
  output logic                    outValid
);
  qnco_strobe_t strobes;

  qnco_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .strobes(strobes), .outValid(outValid)
  );

  qnco_datapath #(
    .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .DITHER_W(DITHER_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tuningWord(tuningWord), .dither(dither),
    .strobes(strobes), .sine(sine), .cosine(cosine)
  );
endmodule

// File: rtl/quarter_wave_nco_chk.sv
module quarter_wave_nco_chk #(
  parameter int PHASE_W = 32,
  parameter int AMP_W   = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    enable,
  input logic [PHASE_W-1:0]      phase,
  input logic signed [AMP_W-1:0] sine,
  input logic signed [AMP_W-1:0] cosine,
  input logic                    outValid
);
  localparam logic signed [AMP_W-1:0] MIN_CODE = {1'b1, {(AMP_W-1){1'b0}}};

  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4) |-> (outValid == $past(enable, 4))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd1 && !outValid) |-> ($stable(sine) && $stable(cosine))); // R6
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(phase)); // R4
  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (sine != MIN_CODE) && (cosine != MIN_CODE)); // R10
endmodule

bind quarter_wave_nco quarter_wave_nco_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .phase(u_dp.phaseAcc),
  .sine(sine), .cosine(cosine), .outValid(outValid)
);

// File: tb/quarter_wave_nco_bench.sv
module quarter_wave_nco_bench;
  localparam int PW = 12;
  localparam int AW = 4;
  localparam int MW = 12;
  localparam int DW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [PW-1:0] tuningWord = '0;
  logic [DW-1:0] dither = '0;
  logic signed [MW-1:0] sine, cosine;
  logic outValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  quarter_wave_nco #(.PHASE_W(PW), .ADDR_W(AW), .AMP_W(MW), .DITHER_W(DW)) u_quarter_wave_nco (
    .clk(clk), .rstN(rstN), .enable(enable), .tuningWord(tuningWord),
    .dither(dither), .sine(sine), .cosine(cosine), .outValid(outValid)
  );

  always #2 clk = ~clk;

  // Reference model state (from the requirements)
  logic [PW-1:0] mInc, mAcc, s2, s3, s4;
  logic [3:0] mV;
  bit loaded4;

  function automatic int tableRef(int k);
    real a = real'((1 << (MW - 1)) - 1);
    return $rtoi(a * $sin(1.5707963267948966 * (real'(k) + 0.5) / real'(N)) + 0.5);
  endfunction

  function automatic int waveRef(logic [PW-1:0] ph, bit isCos);
    int q = int'(ph >> (PW - 2));
    int a = int'((ph >> (PW - 2 - AW)) & (N - 1));
    int v;
    if (isCos) q = (q + 1) % 4;
    v = tableRef((q % 2 == 1) ? (N - 1 - a) : a);
    return (q >= 2) ? -v : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mInc = '0; mAcc = '0; s2 = '0; s3 = '0; s4 = '0; mV = '0; loaded4 = 1'b0;
  endtask

  // Drive inputs, take one edge, update the model, compare at the falling edge.
  task automatic step(bit en, logic [PW-1:0] ftw, logic [DW-1:0] dth, string tag);
    enable = en; tuningWord = ftw; dither = dth;
    @(posedge clk);
    if (mV[2]) begin s4 = s3; loaded4 = 1'b1; end
    if (mV[1]) s3 = s2;
    if (mV[0]) s2 = mAcc;
    if (en) mAcc = mAcc + mInc;
    mInc = ftw + PW'(dth);
    mV = {mV[2:0], en};
    @(negedge clk);
    chk({tag, " R5 valid"}, int'(outValid), int'(mV[3]));
    if (loaded4) begin
      chk({tag, " R8 sine"}, int'(sine), waveRef(s4, 1'b0));
      chk({tag, " R9 cosine"}, int'(cosine), waveRef(s4, 1'b1));
    end
  endtask

  task automatic resetCheck(string tag);
    chk({tag, " R1 sine"}, int'(sine), 0);
    chk({tag, " R1 cosine"}, int'(cosine), 0);
    chk({tag, " R1 valid"}, int'(outValid), 0);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    resetCheck("reset");
    rstN = 1'b1;

    // Unit step: every phase, every table entry, accumulator wrap (R2, R7, R10)
    step(1'b0, PW'(1), '0, "prime");
    for (int i = 0; i < (1 << PW) + 8; i++) step(1'b1, PW'(1), '0, "R2 unit sweep");
    for (int i = 0; i < 4; i++) step(1'b0, PW'(1), '0, "R6 drain");

    // Stride sweep of tuning words; each change lags one edge (R3)
    for (int f = 0; f < (1 << PW); f += 13)
      for (int i = 0; i < 20; i++) step(1'b1, PW'(f), '0, "R3 stride sweep");

    // All dither codes (R3)
    for (int d = 0; d < (1 << DW); d++)
      for (int i = 0; i < 12; i++) step(1'b1, PW'(100), DW'(d), "R3 dither");

    // Gapped enable: phase and outputs hold (R4, R6)
    for (int i = 0; i < 600; i++) step((i % 3) != 0 && (i % 7) != 2, PW'(37), '0, "R4 gapped");

    // Isolated enable pulse: valid only after the fourth edge (R5)
    for (int i = 0; i < 6; i++) step(1'b0, PW'(200), '0, "R5 idle");
    step(1'b1, PW'(200), '0, "R5 pulse");
    for (int i = 0; i < 6; i++) step(1'b0, PW'(200), '0, "R5 tail");

    // Mid-run reset (R1)
    for (int i = 0; i < 10; i++) step(1'b1, PW'(611), '0, "pre-reset");
    @(negedge clk);
    rstN = 1'b0;
    modelReset();
    #1;
    resetCheck("mid reset");
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 40; i++) step(1'b1, PW'(611), DW'(5), "R2 after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule